// File: doc/BRIEF.md
# Bidirectional Port with Change-Detect Wake

An eight-pin general-purpose I/O port that sits on a small register bus. Software sets each pin's direction and output level, reads the synchronised pin levels back, and chooses which pins are analog-only. For each pin it can also enable a weak pull-up. A single global active-low enable gates all of the pull-ups.

The upper four pins feed a change detector. The detector does not compare against the previous clock. It compares against a reference snapshot that is refreshed each time software reads or writes the port. Any difference on an input-configured pin in that group sets a sticky flag and raises a wake request. Clearing the flag does not work while the difference is still present. Software must first access the port to refresh the reference, and only then can the flag stay cleared.

Register map (2-bit address, `reg_rdata` always shows the addressed register):
- 0 is the port. A read returns the pin levels. A write loads the output latch.
- 1 is direction. A 1 selects input.
- 2 is control. Bit 7 is the global pull-up disable. Bit 0 reads as the flag, and writing 1 to it clears the flag.
- 3 is the analog mask. A 1 selects analog.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register reads 0xFF. `pin_oe`, `pin_out` and `pin_pullup_en` are 0, `chg_flag` is 0, `wake_req` is 0 and control bit 7 reads 1.
- R2: A write to address 0 sets `pin_out` to the written byte on the next cycle. `pin_oe` bit i equals the inverse of direction bit i, so only direction-0 pins drive.
- R3: A read of address 0 returns the pin levels through a two-flop synchroniser. A level applied to `pin_in` appears on `reg_rdata` after two rising clock edges.
- R4: Changes on pins 3:0 never set the flag.
- R5: A pin in 7:4 whose direction bit is 0 is excluded from the comparison.
- R6: Each input pin in 7:4 is compared with a snapshot taken on the most recent port read or write (the snapshot resets to 0). A mismatch sets `chg_flag` on the following clock edge.
- R7: A clear (write to address 2 with bit 0 = 1) in a cycle with a mismatch leaves the flag set, because set wins. After a port access has removed the mismatch, a clear takes effect.
- R8: `wake_req` is high whenever the flag is set or a mismatch is present.
- R9: `pin_pullup_en` bit i is 1 exactly when direction bit i is 1 and control bit 7 is 0.
- R10: A pin with its analog mask bit at 1 reads as 0 on address 0, and toggling it never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (refreshes the snapshot when at address 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Output data latch to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pullup_en | output | 8 | Per-pin weak pull-up enable |
| chg_flag | output | 1 | Sticky port-change flag |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
The hardest case to reach is a clear that arrives while a mismatch still exists. The bench changes an upper pin and never touches the port, so the mismatch persists. It then writes a clear and observes the flag set again. Next it reads the port and repeats the clear, which shows the order of access and clear that does work. Random phases switch pins, directions and analog masks at arbitrary times around port accesses. A bench model predicts every output on every cycle.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT = 2'd0,
        REG_DIR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_ANA  = 2'd3
    } reg_sel_e;

    localparam int CTRL_PULLDIS_BIT = 7;
    localparam int CTRL_FLAG_BIT    = 0;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_chg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  data_lat,
    output logic [WIDTH-1:0]  dir_lat,
    output logic [WIDTH-1:0]  ana_lat,
    output logic              pull_dis
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] ana;
        logic             pdis;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (sel)
                REG_PORT: r_d.data = wdata;
                REG_DIR:  r_d.dir  = wdata;
                REG_CTRL: r_d.pdis = wdata[CTRL_PULLDIS_BIT];
                REG_ANA:  r_d.ana  = wdata;
                default:  r_d      = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.data <= '0;
            r_q.dir  <= '1;
            r_q.ana  <= '0;
            r_q.pdis <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_lat = r_q.data;
    assign dir_lat  = r_q.dir;
    assign ana_lat  = r_q.ana;
    assign pull_dis = r_q.pdis;
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
    parameter int WIDTH  = 8,
    parameter int CHG_LO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dig_in,
    input  logic [WIDTH-1:0] dir,
    input  logic             refresh,
    input  logic             clr,
    output logic             mismatch,
    output logic             flag
);
    localparam int CHG_W = WIDTH - CHG_LO;

    typedef struct packed {
        logic [CHG_W-1:0] snap;
        logic             flag;
    } det_t;

    det_t d_d, d_q;
    logic [CHG_W-1:0] pin_miss;

    // per-pin compare against the access-time snapshot, outputs masked
    for (genvar i = 0; i < CHG_W; i++) begin : g_cmp
        assign pin_miss[i] = dir[CHG_LO+i] & (dig_in[CHG_LO+i] ^ d_q.snap[i]);
    end

    assign mismatch = |pin_miss;

    always_comb begin
        d_d      = d_q;
        d_d.flag = (d_q.flag & ~clr) | mismatch;
        if (refresh) d_d.snap = dig_in[WIDTH-1:CHG_LO];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign flag = d_q.flag;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int CHG_LO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pullup_en,
    output logic             chg_flag,
    output logic             wake_req
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dig_in;
    logic [WIDTH-1:0] data_lat, dir_lat, ana_lat;
    logic             pull_dis;
    logic             port_acc;
    logic             flag_clr;
    logic             chg_mismatch;

    assign sel      = reg_sel_e'(reg_addr);
    assign port_acc = (reg_wr | reg_rd) && (sel == REG_PORT);
    assign flag_clr = reg_wr && (sel == REG_CTRL) && reg_wdata[CTRL_FLAG_BIT];

    gpio_in_sync #(.W(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    assign dig_in = pin_sync & ~ana_lat;

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (sel),
        .wdata    (reg_wdata),
        .data_lat (data_lat),
        .dir_lat  (dir_lat),
        .ana_lat  (ana_lat),
        .pull_dis (pull_dis)
    );

    gpio_chg_detect #(.WIDTH(WIDTH), .CHG_LO(CHG_LO)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .dig_in   (dig_in),
        .dir      (dir_lat),
        .refresh  (port_acc),
        .clr      (flag_clr),
        .mismatch (chg_mismatch),
        .flag     (chg_flag)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_PORT: reg_rdata = dig_in;
            REG_DIR:  reg_rdata = dir_lat;
            REG_CTRL: begin
                reg_rdata[CTRL_PULLDIS_BIT] = pull_dis;
                reg_rdata[CTRL_FLAG_BIT]    = chg_flag;
            end
            REG_ANA:  reg_rdata = ana_lat;
            default:  reg_rdata = '0;
        endcase
    end

    assign pin_out       = data_lat;
    assign pin_oe        = ~dir_lat;
    assign pin_pullup_en = dir_lat & {WIDTH{~pull_dis}};
    assign wake_req      = chg_flag | chg_mismatch;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk
    import gpio_chg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [WIDTH-1:0] reg_wdata,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_pullup_en,
    input logic             chg_flag,
    input logic             wake_req,
    input logic             mismatch,
    input logic [WIDTH-1:0] dig_in
);
    logic acc, clr;
    assign acc = (reg_wr | reg_rd) && (reg_addr == REG_PORT);
    assign clr = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[CTRL_FLAG_BIT];

    a_r2_port_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_PORT) |=> (pin_out == $past(reg_wdata)));

    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_DIR) |=> (pin_oe == ~$past(reg_wdata)));

    a_r9_no_pull_on_driver: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pullup_en & pin_oe) == '0));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !clr) |=> chg_flag);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> chg_flag);

    a_r8_wake_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag || mismatch) |-> wake_req);

    a_r6_access_ends_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (!$stable(dig_in) || !mismatch));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_wdata     (reg_wdata),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe),
    .pin_pullup_en (pin_pullup_en),
    .chg_flag      (chg_flag),
    .wake_req      (wake_req),
    .mismatch      (chg_mismatch),
    .dig_in        (dig_in)
);

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [7:0] pin_in = '0, pin_out, pin_oe, pin_pullup_en;
    logic       chg_flag, wake_req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model state
    logic [7:0] m_data = 8'h00, m_dir = 8'hFF, m_ana = 8'h00;
    logic       m_pn = 1'b1, m_flag = 1'b0;
    logic [3:0] m_snap = 4'h0;
    logic [7:0] m_s1 = 8'h00, m_s2 = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_chg_port uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pullup_en(pin_pullup_en), .chg_flag(chg_flag), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] m_dig();
        return m_s2 & ~m_ana;
    endfunction

    function automatic logic m_mism();
        logic [7:0] d;
        d = m_dig();
        return |((d[7:4] ^ m_snap) & m_dir[7:4]);
    endfunction

    function automatic logic [7:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_dig();
            2'd1:    return m_dir;
            2'd2:    return {m_pn, 6'b0, m_flag};
            default: return m_ana;
        endcase
    endfunction

    // one clock: drive at negedge, compare before the edge, update model at the edge
    task automatic step(input logic [1:0] a, input logic w, input logic r,
                        input logic [7:0] wd, input logic [7:0] pins);
        logic [7:0] dig;
        logic mism, acc, clr;
        reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = wd; pin_in = pins;
        #1;
        dig  = m_dig();
        mism = m_mism();
        chk("R2 pin_out", pin_out, m_data);
        chk("R2 pin_oe", pin_oe, ~m_dir);
        chk("R9 pullup", pin_pullup_en, m_dir & {8{~m_pn}});
        chk("R6 flag", {7'b0, chg_flag}, {7'b0, m_flag});
        chk("R8 wake", {7'b0, wake_req}, {7'b0, m_flag | mism});
        chk("R3 rdata", reg_rdata, m_rdata(a));
        @(posedge clk);
        acc = (w | r) && a == 2'd0;
        clr = w && a == 2'd2 && wd[0];
        m_flag = (m_flag & ~clr) | mism;
        if (acc) m_snap = dig[7:4];
        if (w) case (a)
            2'd0: m_data = wd;
            2'd1: m_dir = wd;
            2'd2: m_pn = wd[7];
            default: m_ana = wd;
        endcase
        m_s2 = m_s1; m_s1 = pins;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2'd1, 1'b0, 1'b0, 8'h00, pin_in);
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; reg_wr = 0; reg_rd = 0;
        #1 v = reg_rdata;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 pullup", pin_pullup_en, 8'h00);
        chk("R1 flag/wake", {6'b0, chg_flag, wake_req}, 8'h00);
        peek(2'd1, v); chk("R1 dir", v, 8'hFF);
        peek(2'd2, v); chk("R1 ctrl", v, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 global pull-up enable
        step(2'd2, 1, 0, 8'h00, 8'h00);
        chk("R9 pull all inputs", pin_pullup_en, 8'hFF);
        // R2 direction and data
        step(2'd1, 1, 0, 8'hF0, 8'h00);
        step(2'd0, 1, 0, 8'hA5, 8'h00);
        chk("R2 out", pin_out, 8'hA5);
        chk("R2 oe", pin_oe, 8'h0F);
        chk("R9 pull on inputs", pin_pullup_en, 8'hF0);

        // R3/R8/R6: upper pin change, wake before flag
        step(2'd1, 0, 0, 8'h00, 8'h30);
        step(2'd1, 0, 0, 8'h00, 8'h30);
        chk("R8 wake on mismatch", {7'b0, wake_req}, 8'h01);
        chk("R6 flag not yet", {7'b0, chg_flag}, 8'h00);
        peek(2'd0, v); chk("R3 read sync", v, 8'h30);
        step(2'd1, 0, 0, 8'h00, 8'h30);
        chk("R6 flag set", {7'b0, chg_flag}, 8'h01);
        // R7 clear during mismatch fails
        step(2'd2, 1, 0, 8'h01, 8'h30);
        chk("R7 set wins", {7'b0, chg_flag}, 8'h01);
        step(2'd0, 0, 1, 8'h00, 8'h30);
        step(2'd2, 1, 0, 8'h01, 8'h30);
        chk("R7 clear after access", {7'b0, chg_flag}, 8'h00);
        chk("R8 wake idle", {7'b0, wake_req}, 8'h00);

        // R4 low pins ignored
        step(2'd1, 0, 0, 8'h00, 8'h3F);
        idle(4);
        chk("R4 low pins", {7'b0, wake_req | chg_flag}, 8'h00);
        // R5 output pin excluded
        step(2'd1, 1, 0, 8'h70, 8'h3F);
        step(2'd1, 0, 0, 8'h00, 8'hBF);
        idle(4);
        chk("R5 output excluded", {7'b0, wake_req | chg_flag}, 8'h00);
        // R10 analog pin
        step(2'd3, 1, 0, 8'h40, 8'hBF);
        step(2'd0, 0, 1, 8'h00, 8'hBF);
        step(2'd1, 0, 0, 8'h00, 8'hFF);
        idle(4);
        peek(2'd0, v); chk("R10 analog reads 0", v & 8'h40, 8'h00);
        chk("R10 analog no flag", {7'b0, wake_req | chg_flag}, 8'h00);

        // constrained random
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] a;
            logic [7:0] p;
            int op;
            a  = 2'($urandom_range(0, 3));
            op = $urandom_range(0, 7);
            p  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pin_in;
            step(a, op == 0 || op == 1, op == 2 || op == 3, 8'($urandom), p);
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog got timeout exp completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule